// File: doc/BRIEF.md
# Shared Local-Memory Port Arbiter with AXI Slave Access

This block places a single memory port in front of a core's tightly coupled memory and shares it among three requesters: the core's load/store unit, its instruction prefetch unit, and a 64-bit AXI slave port. External masters reach the memory at the same byte addresses the core uses, so the memory map is uniform. The slave always yields. In any cycle in which either core requester asks for the port, the slave's pending beat waits. When both core units ask in the same cycle, the load/store unit wins.

The slave serves one transaction at a time. Every transfer is an incrementing burst of full 64-bit beats, with byte strobes on writes. The memory protection unit does not check slave traffic. Instead, a configuration input selects one of two policies: any access is accepted, or only accesses marked privileged are accepted. A refused access still completes its burst. It returns an error response, it never writes memory, and on reads it returns zero data. Locked and exclusive requests are performed as plain accesses. No exclusive state is kept for them, and they are answered with a plain OKAY, which tells the master that exclusivity failed. A build parameter can remove the slave entirely, leaving a two-way arbiter for the core.

The memory has a fixed read latency of one cycle. Read data appears on `memRdata` in the cycle after the port request, for whichever requester was granted.

Top module: `tcm_share_arbiter`

## Requirements
- R1: An accepted slave write stores the bytes enabled by `sWStrb` (bit i enables byte i) at the beat's address. The same word is then visible to the load/store unit at that identical address, and a slave read returns it.
- R2: When `lsuReq` and `pfuReq` are both high, `lsuGnt`=1, `pfuGnt`=0 and the memory port carries the load/store address. When only `pfuReq` is high, `pfuGnt`=1 and the port carries `pfuAddr`.
- R3: While `lsuReq` or `pfuReq` is high, the slave never drives the memory port. An accepted write beat waits with `sWReady`=0 and a read beat issues no request (`sRValid` stays 0) until the core releases the port.
- R4: With `cfgUnprivOk`=0, an access whose privilege bit is 0 is refused. It answers SLVERR (2'b10), leaves memory unchanged, and returns zero read data on every beat.
- R5: With `cfgUnprivOk`=1, an unprivileged access completes normally with OKAY (2'b00). Privileged accesses are always accepted.
- R6: A request with its lock bit set is carried out as a normal access and answered OKAY (2'b00), never EXOKAY (2'b01).
- R7: A burst of length field L carries L+1 beats. Beat i uses address start+8*i, and `sRLast` is high only on the final read beat.
- R8: `sBId` and `sRId` return the ID of the transaction being answered.
- R9: With the slave excluded by parameter, the AXI ready and valid outputs stay 0 and the core requesters are still granted.
- R10: After reset, `sBValid`, `sRValid` and `memReq` are 0 and the slave is ready for a new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgUnprivOk | input | 1 | 1: unprivileged slave accesses allowed |
| lsuReq | input | 1 | Load/store unit request |
| lsuWe | input | 1 | Load/store write enable |
| lsuAddr | input | ADDR_W | Load/store byte address |
| lsuWdata | input | 64 | Load/store write data |
| lsuStrb | input | 8 | Load/store byte enables |
| lsuGnt | output | 1 | Load/store granted this cycle |
| pfuReq | input | 1 | Prefetch read request |
| pfuAddr | input | ADDR_W | Prefetch byte address |
| pfuGnt | output | 1 | Prefetch granted this cycle |
| memReq | output | 1 | Memory cycle request |
| memWe | output | 1 | Memory write enable |
| memAddr | output | ADDR_W | Memory byte address |
| memWdata | output | 64 | Memory write data |
| memStrb | output | 8 | Memory byte enables |
| memRdata | input | 64 | Memory read data, one cycle after request |
| sAwValid | input | 1 | Write address valid |
| sAwReady | output | 1 | Write address ready |
| sAwAddr | input | ADDR_W | Write start address |
| sAwLen | input | LEN_W | Write beats minus one |
| sAwId | input | ID_W | Write ID |
| sAwPriv | input | 1 | Write privileged bit |
| sAwLock | input | 1 | Write exclusive request |
| sWValid | input | 1 | Write data valid |
| sWReady | output | 1 | Write data ready |
| sWData | input | 64 | Write data |
| sWStrb | input | 8 | Write byte enables |
| sWLast | input | 1 | Final write beat |
| sBValid | output | 1 | Write response valid |
| sBReady | input | 1 | Write response ready |
| sBId | output | ID_W | Write response ID |
| sBResp | output | 2 | Write response code |
| sArValid | input | 1 | Read address valid |
| sArReady | output | 1 | Read address ready |
| sArAddr | input | ADDR_W | Read start address |
| sArLen | input | LEN_W | Read beats minus one |
| sArId | input | ID_W | Read ID |
| sArPriv | input | 1 | Read privileged bit |
| sArLock | input | 1 | Read exclusive request |
| sRValid | output | 1 | Read data valid |
| sRReady | input | 1 | Read data ready |
| sRData | output | 64 | Read data |
| sRId | output | ID_W | Read ID |
| sRResp | output | 2 | Read response code |
| sRLast | output | 1 | Final read beat |

## Verification
Core grants and the memory-port mux are combinational, so the bench checks them shortly after the negative edge on which it drives the request. Memory contents seen by the load/store unit are checked one edge after the request, because the read data comes out of a one-cycle memory. A granted slave read beat spends one cycle requesting the memory and one capturing the data, so `sRValid` is due two edges after the grant. The bench waits for each valid or ready at a negative edge and then completes the handshake at the next positive edge. To test blocking, the bench holds a core request for several cycles and checks at each negative edge that the slave's ready or valid stays low.

// File: rtl/tcm_share_pkg.sv
package tcm_share_pkg;
  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  typedef enum logic [2:0] {
    S_IDLE, S_WDATA, S_WRESP, S_RREQ, S_RCAP, S_RSEND
  } slvState_t;

  typedef struct packed {
    logic ldAw;   // latch write address channel
    logic ldAr;   // latch read address channel
    logic memRd;  // slave wants a memory read
    logic memWr;  // slave wants a memory write
    logic step;   // advance beat address and count
    logic cap;    // capture read data
  } slvStrobe_t;
endpackage

// File: rtl/tcm_share_dp.sv
module tcm_share_dp
  import tcm_share_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgUnprivOk,
  input  slvStrobe_t        strb,
  input  logic              lsuReq,
  input  logic              lsuWe,
  input  logic [ADDR_W-1:0] lsuAddr,
  input  logic [63:0]       lsuWdata,
  input  logic [7:0]        lsuStrb,
  input  logic              pfuReq,
  input  logic [ADDR_W-1:0] pfuAddr,
  output logic              lsuGnt,
  output logic              pfuGnt,
  output logic              slvGnt,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [63:0]       memWdata,
  output logic [7:0]        memStrb,
  input  logic [63:0]       memRdata,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic [LEN_W-1:0]  awLen,
  input  logic [ID_W-1:0]   awId,
  input  logic              awPriv,
  input  logic              awLock,
  input  logic [ADDR_W-1:0] arAddr,
  input  logic [LEN_W-1:0]  arLen,
  input  logic [ID_W-1:0]   arId,
  input  logic              arPriv,
  input  logic              arLock,
  input  logic [63:0]       wData,
  input  logic [7:0]        wStrb,
  output logic              allow,
  output logic              lastBeat,
  output logic [ID_W-1:0]   curId,
  output logic [1:0]        respCode,
  output logic [63:0]       rData
);
  localparam int BEAT_BYTES = 8;
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(BEAT_BYTES);

  logic [ADDR_W-1:0] addrReg;
  logic [LEN_W-1:0]  cntReg;
  logic [ID_W-1:0]   idReg;
  logic              allowReg;
  logic              exclReg;
  logic              coreBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      cntReg   <= '0;
      idReg    <= '0;
      allowReg <= 1'b0;
      exclReg  <= 1'b0;
      rData    <= '0;
    end else begin
      if (strb.ldAw) begin
        addrReg  <= awAddr;
        cntReg   <= awLen;
        idReg    <= awId;
        allowReg <= cfgUnprivOk | awPriv;
        exclReg  <= awLock;
      end else if (strb.ldAr) begin
        addrReg  <= arAddr;
        cntReg   <= arLen;
        idReg    <= arId;
        allowReg <= cfgUnprivOk | arPriv;
        exclReg  <= arLock;
      end else if (strb.step) begin
        addrReg <= addrReg + ADDR_STEP;
        if (cntReg != '0) cntReg <= cntReg - 1'b1;
      end
      if (strb.cap) rData <= allowReg ? memRdata : '0;
    end
  end

  // Fixed priority: load/store, then prefetch, then slave.
  assign coreBusy = lsuReq | pfuReq;
  assign lsuGnt   = lsuReq;
  assign pfuGnt   = pfuReq & ~lsuReq;
  assign slvGnt   = (strb.memRd | strb.memWr) & ~coreBusy;

  always_comb begin
    memReq   = coreBusy | slvGnt;
    memWe    = 1'b0;
    memAddr  = addrReg;
    memWdata = wData;
    memStrb  = wStrb;
    if (lsuReq) begin
      memWe    = lsuWe;
      memAddr  = lsuAddr;
      memWdata = lsuWdata;
      memStrb  = lsuStrb;
    end else if (pfuReq) begin
      memAddr = pfuAddr;
      memStrb = '1;
    end else if (slvGnt) begin
      memWe = strb.memWr;
    end
  end

  // Exclusive requests get a plain OKAY: exclusivity never succeeds.
  assign allow    = allowReg;
  assign lastBeat = (cntReg == '0);
  assign curId    = idReg;
  assign respCode = allowReg ? RESP_OKAY : RESP_SLVERR;

  a_r2_single_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({lsuGnt, pfuGnt, slvGnt}));
  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.ldAw && !strb.ldAr) |=> addrReg == $past(addrReg) + ADDR_STEP);
  a_r4_no_denied_write: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && !lsuReq) |-> allowReg);
  a_r6_excl_plain_okay: assert property (@(posedge clk) disable iff (!rstN)
    (exclReg && allowReg) |-> respCode == RESP_OKAY);
endmodule

// File: rtl/tcm_share_ctrl.sv
module tcm_share_ctrl
  import tcm_share_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       awValid,
  output logic       awReady,
  input  logic       arValid,
  output logic       arReady,
  input  logic       wValid,
  output logic       wReady,
  input  logic       wLast,
  output logic       bValid,
  input  logic       bReady,
  output logic       rValid,
  input  logic       rReady,
  input  logic       allow,
  input  logic       lastBeat,
  input  logic       slvGnt,
  output slvStrobe_t strb
);
  slvState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    awReady   = 1'b0;
    arReady   = 1'b0;
    wReady    = 1'b0;
    bValid    = 1'b0;
    rValid    = 1'b0;
    unique case (state)
      S_IDLE: begin
        awReady = 1'b1;
        arReady = ~awValid;
        if (awValid) begin
          strb.ldAw = 1'b1;
          stateNext = S_WDATA;
        end else if (arValid) begin
          strb.ldAr = 1'b1;
          stateNext = S_RREQ;
        end
      end
      S_WDATA: begin
        strb.memWr = wValid & allow;
        wReady     = allow ? slvGnt : 1'b1;
        if (wValid && wReady) begin
          strb.step = 1'b1;
          if (wLast) stateNext = S_WRESP;
        end
      end
      S_WRESP: begin
        bValid = 1'b1;
        if (bReady) stateNext = S_IDLE;
      end
      S_RREQ: begin
        strb.memRd = allow;
        if (!allow || slvGnt) stateNext = S_RCAP;
      end
      S_RCAP: begin
        strb.cap  = 1'b1;
        stateNext = S_RSEND;
      end
      S_RSEND: begin
        rValid = 1'b1;
        if (rReady) begin
          strb.step = 1'b1;
          stateNext = lastBeat ? S_IDLE : S_RREQ;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  a_r1_rvalid_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && !rReady) |=> rValid);
  a_r7_last_ends_burst: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && rReady && lastBeat) |=> !rValid);
  a_r4_refused_beat_free: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WDATA && !allow) |-> wReady);
endmodule

// File: rtl/tcm_share_arbiter.sv
module tcm_share_arbiter
  import tcm_share_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int LEN_W    = 8,
  parameter int ID_W     = 4,
  parameter bit SLAVE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgUnprivOk,
  input  logic              lsuReq,
  input  logic              lsuWe,
  input  logic [ADDR_W-1:0] lsuAddr,
  input  logic [63:0]       lsuWdata,
  input  logic [7:0]        lsuStrb,
  output logic              lsuGnt,
  input  logic              pfuReq,
  input  logic [ADDR_W-1:0] pfuAddr,
  output logic              pfuGnt,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [63:0]       memWdata,
  output logic [7:0]        memStrb,
  input  logic [63:0]       memRdata,
  input  logic              sAwValid,
  output logic              sAwReady,
  input  logic [ADDR_W-1:0] sAwAddr,
  input  logic [LEN_W-1:0]  sAwLen,
  input  logic [ID_W-1:0]   sAwId,
  input  logic              sAwPriv,
  input  logic              sAwLock,
  input  logic              sWValid,
  output logic              sWReady,
  input  logic [63:0]       sWData,
  input  logic [7:0]        sWStrb,
  input  logic              sWLast,
  output logic              sBValid,
  input  logic              sBReady,
  output logic [ID_W-1:0]   sBId,
  output logic [1:0]        sBResp,
  input  logic              sArValid,
  output logic              sArReady,
  input  logic [ADDR_W-1:0] sArAddr,
  input  logic [LEN_W-1:0]  sArLen,
  input  logic [ID_W-1:0]   sArId,
  input  logic              sArPriv,
  input  logic              sArLock,
  output logic              sRValid,
  input  logic              sRReady,
  output logic [63:0]       sRData,
  output logic [ID_W-1:0]   sRId,
  output logic [1:0]        sRResp,
  output logic              sRLast
);
  slvStrobe_t        strb;
  logic              slvGnt, allow, lastBeat;
  logic [ID_W-1:0]   curId;
  logic [1:0]        respCode;

  tcm_share_dp #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .ID_W(ID_W)) dp (
    .clk(clk), .rstN(rstN), .cfgUnprivOk(cfgUnprivOk), .strb(strb),
    .lsuReq(lsuReq), .lsuWe(lsuWe), .lsuAddr(lsuAddr), .lsuWdata(lsuWdata),
    .lsuStrb(lsuStrb), .pfuReq(pfuReq), .pfuAddr(pfuAddr),
    .lsuGnt(lsuGnt), .pfuGnt(pfuGnt), .slvGnt(slvGnt),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memStrb(memStrb), .memRdata(memRdata),
    .awAddr(sAwAddr), .awLen(sAwLen), .awId(sAwId), .awPriv(sAwPriv), .awLock(sAwLock),
    .arAddr(sArAddr), .arLen(sArLen), .arId(sArId), .arPriv(sArPriv), .arLock(sArLock),
    .wData(sWData), .wStrb(sWStrb),
    .allow(allow), .lastBeat(lastBeat), .curId(curId), .respCode(respCode),
    .rData(sRData)
  );

  generate
    if (SLAVE_EN) begin : g_slave
      tcm_share_ctrl ctrl (
        .clk(clk), .rstN(rstN),
        .awValid(sAwValid), .awReady(sAwReady),
        .arValid(sArValid), .arReady(sArReady),
        .wValid(sWValid), .wReady(sWReady), .wLast(sWLast),
        .bValid(sBValid), .bReady(sBReady),
        .rValid(sRValid), .rReady(sRReady),
        .allow(allow), .lastBeat(lastBeat), .slvGnt(slvGnt), .strb(strb)
      );
    end else begin : g_noslave
      assign strb     = '0;
      assign sAwReady = 1'b0;
      assign sArReady = 1'b0;
      assign sWReady  = 1'b0;
      assign sBValid  = 1'b0;
      assign sRValid  = 1'b0;
    end
  endgenerate

  assign sBId   = curId;
  assign sRId   = curId;
  assign sBResp = respCode;
  assign sRResp = respCode;
  assign sRLast = lastBeat;

  a_r3_core_owns_port: assert property (@(posedge clk) disable iff (!rstN)
    (lsuReq || pfuReq) |-> memAddr == (lsuReq ? lsuAddr : pfuAddr));
  a_r10_quiet_after_reset: assert property (@(posedge clk)
    $rose(rstN) |-> !sBValid && !sRValid);
endmodule

// File: tb/tcm_share_arbiter_test.sv
module tcm_share_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic cfgUnprivOk = 1'b0;
  logic lsuReq = 0, lsuWe = 0, pfuReq = 0;
  logic [AW-1:0] lsuAddr = '0, pfuAddr = '0;
  logic [63:0] lsuWdata = '0;
  logic [7:0] lsuStrb = '0;
  logic lsuGnt, pfuGnt, memReq, memWe;
  logic [AW-1:0] memAddr;
  logic [63:0] memWdata, memRdata;
  logic [7:0] memStrb;
  logic sAwValid = 0, sAwPriv = 0, sAwLock = 0;
  logic [AW-1:0] sAwAddr = '0;
  logic [7:0] sAwLen = '0;
  logic [3:0] sAwId = '0;
  logic sWValid = 0, sWLast = 0;
  logic [63:0] sWData = '0;
  logic [7:0] sWStrb = '0;
  logic sBReady = 1'b1, sRReady = 1'b1;
  logic sArValid = 0, sArPriv = 0, sArLock = 0;
  logic [AW-1:0] sArAddr = '0;
  logic [7:0] sArLen = '0;
  logic [3:0] sArId = '0;
  logic sAwReady, sWReady, sBValid, sArReady, sRValid, sRLast;
  logic [3:0] sBId, sRId;
  logic [1:0] sBResp, sRResp;
  logic [63:0] sRData;

  // Variant without the slave port
  logic nAwValid = 0, nArValid = 0;
  logic nLsuGnt, nPfuGnt, nMemReq, nMemWe, nAwReady, nWReady, nBValid, nArReady;
  logic nRValid, nRLast;
  logic [AW-1:0] nMemAddr;
  logic [63:0] nMemWdata, nRData;
  logic [7:0] nMemStrb;
  logic [3:0] nBId, nRId;
  logic [1:0] nBResp, nRResp;

  tcm_share_arbiter uut (
    .clk(clk), .rstN(rstN), .cfgUnprivOk(cfgUnprivOk),
    .lsuReq(lsuReq), .lsuWe(lsuWe), .lsuAddr(lsuAddr), .lsuWdata(lsuWdata),
    .lsuStrb(lsuStrb), .lsuGnt(lsuGnt), .pfuReq(pfuReq), .pfuAddr(pfuAddr),
    .pfuGnt(pfuGnt), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memStrb(memStrb), .memRdata(memRdata),
    .sAwValid(sAwValid), .sAwReady(sAwReady), .sAwAddr(sAwAddr), .sAwLen(sAwLen),
    .sAwId(sAwId), .sAwPriv(sAwPriv), .sAwLock(sAwLock),
    .sWValid(sWValid), .sWReady(sWReady), .sWData(sWData), .sWStrb(sWStrb),
    .sWLast(sWLast), .sBValid(sBValid), .sBReady(sBReady), .sBId(sBId),
    .sBResp(sBResp), .sArValid(sArValid), .sArReady(sArReady), .sArAddr(sArAddr),
    .sArLen(sArLen), .sArId(sArId), .sArPriv(sArPriv), .sArLock(sArLock),
    .sRValid(sRValid), .sRReady(sRReady), .sRData(sRData), .sRId(sRId),
    .sRResp(sRResp), .sRLast(sRLast)
  );

  tcm_share_arbiter #(.SLAVE_EN(1'b0)) uutNoSlv (
    .clk(clk), .rstN(rstN), .cfgUnprivOk(cfgUnprivOk),
    .lsuReq(lsuReq), .lsuWe(lsuWe), .lsuAddr(lsuAddr), .lsuWdata(lsuWdata),
    .lsuStrb(lsuStrb), .lsuGnt(nLsuGnt), .pfuReq(pfuReq), .pfuAddr(pfuAddr),
    .pfuGnt(nPfuGnt), .memReq(nMemReq), .memWe(nMemWe), .memAddr(nMemAddr),
    .memWdata(nMemWdata), .memStrb(nMemStrb), .memRdata(64'h0),
    .sAwValid(nAwValid), .sAwReady(nAwReady), .sAwAddr(sAwAddr), .sAwLen(sAwLen),
    .sAwId(sAwId), .sAwPriv(sAwPriv), .sAwLock(sAwLock),
    .sWValid(sWValid), .sWReady(nWReady), .sWData(sWData), .sWStrb(sWStrb),
    .sWLast(sWLast), .sBValid(nBValid), .sBReady(sBReady), .sBId(nBId),
    .sBResp(nBResp), .sArValid(nArValid), .sArReady(nArReady), .sArAddr(sArAddr),
    .sArLen(sArLen), .sArId(sArId), .sArPriv(sArPriv), .sArLock(sArLock),
    .sRValid(nRValid), .sRReady(sRReady), .sRData(nRData), .sRId(nRId),
    .sRResp(nRResp), .sRLast(nRLast)
  );

  // One-cycle-latency memory model, 256 words
  logic [63:0] ram [256];
  always_ff @(posedge clk) begin
    if (memReq) begin
      if (memWe) begin
        for (int b = 0; b < 8; b++)
          if (memStrb[b]) ram[memAddr[10:3]][b*8 +: 8] <= memWdata[b*8 +: 8];
      end else begin
        memRdata <= ram[memAddr[10:3]];
      end
    end
  end

  function automatic logic [63:0] pat(int i);
    return {32'hC0DE_0000 + 32'(i), 32'h0000_5A00 + 32'(i)};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a negative edge.
  task automatic doAw(logic [AW-1:0] a, logic [7:0] len, logic [3:0] id, logic priv, logic lock);
    sAwValid = 1; sAwAddr = a; sAwLen = len; sAwId = id; sAwPriv = priv; sAwLock = lock;
    #1; while (!sAwReady) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk); sAwValid = 0;
  endtask

  task automatic doW(logic [63:0] d, logic [7:0] s, logic last);
    sWValid = 1; sWData = d; sWStrb = s; sWLast = last;
    #1; while (!sWReady) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk); sWValid = 0; sWLast = 0;
  endtask

  task automatic doB(string req, logic [1:0] resp, logic [3:0] id);
    #1; while (!sBValid) begin @(negedge clk); #1; end
    chk(req, 64'(sBResp), 64'(resp));
    chk("R8 bid", 64'(sBId), 64'(id));
    @(posedge clk); @(negedge clk);
  endtask

  task automatic doAr(logic [AW-1:0] a, logic [7:0] len, logic [3:0] id, logic priv, logic lock);
    sArValid = 1; sArAddr = a; sArLen = len; sArId = id; sArPriv = priv; sArLock = lock;
    #1; while (!sArReady) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk); sArValid = 0;
  endtask

  task automatic doR(string req, logic [63:0] d, logic [1:0] resp, logic last, logic [3:0] id);
    #1; while (!sRValid) begin @(negedge clk); #1; end
    chk(req, sRData, d);
    chk({req, " resp"}, 64'(sRResp), 64'(resp));
    chk("R7 rlast", 64'(sRLast), 64'(last));
    chk("R8 rid", 64'(sRId), 64'(id));
    @(posedge clk); @(negedge clk);
  endtask

  task automatic lsuRead(logic [AW-1:0] a, output logic [63:0] d);
    lsuReq = 1; lsuWe = 0; lsuAddr = a;
    @(posedge clk); @(negedge clk);
    lsuReq = 0; d = memRdata;
  endtask

  task automatic testReset;
    chk("R10 bvalid", 64'(sBValid), 0);
    chk("R10 rvalid", 64'(sRValid), 0);
    chk("R10 memReq", 64'(memReq), 0);
    chk("R10 awready", 64'(sAwReady), 1);
  endtask

  task automatic testPriority;
    lsuReq = 1; lsuAddr = 16'h0018; pfuReq = 1; pfuAddr = 16'h0220; #1;
    chk("R2 lsuGnt", 64'(lsuGnt), 1);
    chk("R2 pfuGnt", 64'(pfuGnt), 0);
    chk("R2 memAddr lsu", 64'(memAddr), 64'h0018);
    lsuReq = 0; #1;
    chk("R2 pfuGnt alone", 64'(pfuGnt), 1);
    chk("R2 memAddr pfu", 64'(memAddr), 64'h0220);
    @(negedge clk); pfuReq = 0;
  endtask

  task automatic testWriteShared;
    logic [63:0] d;
    cfgUnprivOk = 0;
    doAw(16'h0040, 0, 4'h3, 1, 0);
    doW(64'h1122_3344_5566_7788, 8'hFF, 1);
    doB("R5 priv write okay", 2'b00, 4'h3);
    lsuRead(16'h0040, d);
    chk("R1 lsu sees slave write", d, 64'h1122_3344_5566_7788);
    doAw(16'h0040, 0, 4'h4, 1, 0);
    doW(64'hAAAA_AAAA_AAAA_AAAA, 8'h0F, 1);
    doB("R1 strobe write okay", 2'b00, 4'h4);
    lsuRead(16'h0040, d);
    chk("R1 strobe bytes", d, 64'h1122_3344_AAAA_AAAA);
  endtask

  task automatic testBurst;
    logic [63:0] d;
    doAw(16'h0100, 3, 4'h7, 1, 0);
    for (int i = 0; i < 4; i++) doW(pat(i), 8'hFF, i == 3);
    doB("R7 burst write okay", 2'b00, 4'h7);
    lsuRead(16'h0118, d);
    chk("R7 beat 3 address", d, pat(3));
    doAr(16'h0100, 3, 4'h9, 1, 0);
    for (int i = 0; i < 4; i++) doR("R7 burst read", pat(i), 2'b00, i == 3, 4'h9);
  endtask

  task automatic testDeny;
    logic [63:0] d;
    cfgUnprivOk = 0;
    doAw(16'h0040, 0, 4'h2, 0, 0);
    doW(64'hDEAD_DEAD_DEAD_DEAD, 8'hFF, 1);
    doB("R4 denied write slverr", 2'b10, 4'h2);
    lsuRead(16'h0040, d);
    chk("R4 memory unchanged", d, 64'h1122_3344_AAAA_AAAA);
    doAr(16'h0100, 1, 4'h5, 0, 0);
    doR("R4 denied read zero", 64'h0, 2'b10, 0, 4'h5);
    doR("R4 denied read zero", 64'h0, 2'b10, 1, 4'h5);
  endtask

  task automatic testUnpriv;
    logic [63:0] d;
    cfgUnprivOk = 1;
    doAw(16'h0080, 0, 4'h1, 0, 0);
    doW(64'h0123_4567_89AB_CDEF, 8'hFF, 1);
    doB("R5 unpriv write okay", 2'b00, 4'h1);
    lsuRead(16'h0080, d);
    chk("R5 unpriv data stored", d, 64'h0123_4567_89AB_CDEF);
    cfgUnprivOk = 0;
  endtask

  task automatic testExclusive;
    doAw(16'h0088, 0, 4'hA, 1, 1);
    doW(64'h0F0F_0F0F_F0F0_F0F0, 8'hFF, 1);
    doB("R6 excl write okay", 2'b00, 4'hA);
    doAr(16'h0088, 0, 4'hB, 1, 1);
    doR("R6 excl read okay", 64'h0F0F_0F0F_F0F0_F0F0, 2'b00, 1, 4'hB);
  endtask

  task automatic testBlocking;
    doAw(16'h00C0, 0, 4'h6, 1, 0);
    lsuReq = 1; lsuWe = 0; lsuAddr = 16'h0008;
    sWValid = 1; sWData = 64'h7777_6666_5555_4444; sWStrb = 8'hFF; sWLast = 1;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk("R3 wready held low", 64'(sWReady), 0);
      chk("R3 port to lsu", 64'(memAddr), 64'h0008);
      @(negedge clk);
    end
    lsuReq = 0;
    #1; chk("R3 wready after release", 64'(sWReady), 1);
    @(posedge clk); @(negedge clk); sWValid = 0; sWLast = 0;
    doB("R3 blocked write okay", 2'b00, 4'h6);
    pfuReq = 1; pfuAddr = 16'h0010;
    doAr(16'h00C0, 0, 4'h8, 1, 0);
    for (int k = 0; k < 4; k++) begin
      #1; chk("R3 rvalid held low", 64'(sRValid), 0);
      @(negedge clk);
    end
    pfuReq = 0;
    doR("R3 read after release", 64'h7777_6666_5555_4444, 2'b00, 1, 4'h8);
  endtask

  task automatic testNoSlave;
    nAwValid = 1; nArValid = 1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R9 no awready", 64'(nAwReady), 0);
      chk("R9 no arready", 64'(nArReady), 0);
      chk("R9 no bvalid/rvalid", 64'({nBValid, nRValid}), 0);
      @(negedge clk);
    end
    nAwValid = 0; nArValid = 0;
    lsuReq = 1; lsuAddr = 16'h0030; #1;
    chk("R9 lsu still granted", 64'({nLsuGnt, nMemReq}), 64'b11);
    @(negedge clk); lsuReq = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = '0;
    memRdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset;
    testPriority;
    testWriteShared;
    testBurst;
    testDeny;
    testUnpriv;
    testExclusive;
    testBlocking;
    testNoSlave;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule